// File: doc/BRIEF.md
# Processor exception entry controller

This block carries out the one-cycle register update that a pipelined processor core performs when it takes an exception. The pipeline presents a fault request with a fault kind, the faulting virtual address, the coprocessor number involved and the current and next program counters. On the next clock edge the block commits every control-register change that belongs to that entry at once. It then drives a redirect of the three program-counter slots to the handler address. A separate reset-entry request sends the core to the boot address.

The block holds eight 32-bit control registers: machine state, fault cause, shadow-set control, vector base, return address, bad address, translation tag and translation context. The pipeline reads them through a combinational read port and writes them through a plain write port. Request pins carry no back-pressure. The block has no ready signal, and every request seen at a rising edge is taken on that edge. A write on the same edge as an entry is dropped, so the pipeline must not issue one while it raises a request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the machine-state register reads 0x0040_0000 (boot-vector bit 22 set), the vector base reads 0x8000_0000, the other six registers read 0, and `entry_done` is low.
- R2: A fault request without reset entry sets machine-state bit 1 (exception level) even if it was already set. It raises `entry_done` for exactly the following cycle, with `redir_pc` = handler, `redir_npc` = handler+4 and `redir_nnpc` = handler+8. With no request, `entry_done` stays low.
- R3: Cause bits 6:2 receive the code for `fault_kind`: 0 interrupt→0x0, 1 translation modified→0x1, 2 load invalid→0x2, 3 load refill→0x2, 4 store invalid→0x3, 5 store refill→0x3, 6 load address error→0x4, 7 store address error→0x5, 8 system call→0x8, 9 breakpoint→0x9, 10 reserved instruction→0xA, 11 coprocessor unusable→0xB, 12 overflow→0xC, 13 trap→0xD, 14/15→0xD.
- R4: When `cur_pc`+4 differs from `cur_npc`, the faulting instruction sits in a delay slot. The return address gets `cur_pc`-4 and cause bit 31 is set. Otherwise the return address gets `cur_pc` and bit 31 is cleared.
- R5: Cause bits 29:28 are cleared on every entry, except for kind 11, where they take `cop_id`.
- R6: Shadow sets are switched only if exception level (bit 1) and boot-vector (bit 22) were both 0 before the entry. In that case shadow-control bits 9:6 receive the old bits 3:0, bits 3:0 receive bits 15:12, and `shadow_set` (always bits 3:0) follows. Otherwise the shadow-control register is unchanged.
- R7: Kinds without a special rule vector to vector base + 0x180.
- R8: Refill kinds 3 and 5 vector to vector base + 0x000 when the exception level was 0 before the entry, and to base + 0x180 when it was 1.
- R9: Kind 0 vectors to base + 0x200 when cause bit 23 is 1, and to base + 0x180 when it is 0.
- R10: Kind 12 vectors to the fixed address 0xBFC0_0200 when machine-state bit 22 is 1.
- R11: Kinds 1 to 7 copy `fault_va` into the bad-address register. Kinds 1 to 5 also copy `fault_va`[31:13] into tag bits 31:13 and context bits 22:4, leaving the other bits of both registers alone. The other kinds leave all three registers unchanged.
- R12: `reset_req` beats a simultaneous fault request. It redirects to 0xBFC0_0000, sets machine-state bit 29 and leaves every other register bit unchanged.
- R13: `wr_en` loads `wr_data` into the register chosen by `wr_sel` (0 state, 1 cause, 2 shadow control, 3 vector base, 4 return address, 5 bad address, 6 tag, 7 context) at the next edge. `rd_data` shows the register chosen by `rd_sel` combinationally. A write on the same edge as any entry is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_valid | input | 1 | Fault request, taken at the next edge |
| fault_kind | input | 4 | Fault kind code (R3) |
| fault_va | input | 32 | Faulting virtual address |
| cop_id | input | 2 | Coprocessor number for kind 11 |
| cur_pc | input | 32 | Address of the faulting instruction |
| cur_npc | input | 32 | Next program counter |
| reset_req | input | 1 | Reset-entry request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Selected register value |
| entry_done | output | 1 | One-cycle pulse after an entry |
| redir_pc | output | 32 | New program counter |
| redir_npc | output | 32 | New next program counter |
| redir_nnpc | output | 32 | New next-next program counter |
| shadow_set | output | 4 | Active shadow register set |

## Verification
The bench aims at the conditions that depend on state from before the entry. Refill vectoring must use the exception level from before the entry and not the one being set. A design that sampled it late would send a first-level refill to offset 0x180. Shadow switching is tested with the level set and with the boot-vector bit set, where a wrong design would rotate the set fields anyway. The bench also drives delay-slot and straight-line entries, coprocessor-unusable entries followed by a trap, and a reset entry that collides with a fault and a write. A wrong design would leave a stale coprocessor number, take the fault code, or commit the dropped write.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NCSR = 8;

  // register slots, matching the write/read select encoding
  localparam int unsigned I_STAT   = 0;
  localparam int unsigned I_CAUSE  = 1;
  localparam int unsigned I_SHADOW = 2;
  localparam int unsigned I_VBASE  = 3;
  localparam int unsigned I_RETPC  = 4;
  localparam int unsigned I_FADDR  = 5;
  localparam int unsigned I_TAG    = 6;
  localparam int unsigned I_CTX    = 7;

  // machine-state fields
  localparam int unsigned ST_LVL  = 1;
  localparam int unsigned ST_BOOT = 22;
  localparam int unsigned ST_FPU  = 29;
  // cause fields
  localparam int unsigned CA_SLOT    = 31;
  localparam int unsigned CA_COP_LO  = 28;
  localparam int unsigned CA_COP_W   = 2;
  localparam int unsigned CA_IVSEP   = 23;
  localparam int unsigned CA_CODE_LO = 2;
  localparam int unsigned CA_CODE_W  = 5;
  // shadow-control fields
  localparam int unsigned SH_W        = 4;
  localparam int unsigned SH_CUR_LO   = 0;
  localparam int unsigned SH_PREV_LO  = 6;
  localparam int unsigned SH_ENTRY_LO = 12;
  // page number fields
  localparam int unsigned PG_LO   = 13;
  localparam int unsigned PG_W    = DW - PG_LO;
  localparam int unsigned CTX_LO  = 4;

  typedef logic [NCSR-1:0][DW-1:0] csr_vec_t;

  typedef enum logic [3:0] {
    FK_IRQ        = 4'd0,
    FK_TLB_MOD    = 4'd1,
    FK_LD_INV     = 4'd2,
    FK_LD_REFILL  = 4'd3,
    FK_ST_INV     = 4'd4,
    FK_ST_REFILL  = 4'd5,
    FK_ADR_LD     = 4'd6,
    FK_ADR_ST     = 4'd7,
    FK_SYSCALL    = 4'd8,
    FK_BREAK      = 4'd9,
    FK_RESV       = 4'd10,
    FK_COP        = 4'd11,
    FK_OVF        = 4'd12,
    FK_TRAP       = 4'd13,
    FK_SPARE0     = 4'd14,
    FK_SPARE1     = 4'd15
  } fault_kind_e;

  function automatic logic [CA_CODE_W-1:0] code_of(fault_kind_e k);
    case (k)
      FK_IRQ:                 return 5'h00;
      FK_TLB_MOD:             return 5'h01;
      FK_LD_INV, FK_LD_REFILL: return 5'h02;
      FK_ST_INV, FK_ST_REFILL: return 5'h03;
      FK_ADR_LD:              return 5'h04;
      FK_ADR_ST:              return 5'h05;
      FK_SYSCALL:             return 5'h08;
      FK_BREAK:               return 5'h09;
      FK_RESV:                return 5'h0A;
      FK_COP:                 return 5'h0B;
      FK_OVF:                 return 5'h0C;
      default:                return 5'h0D;
    endcase
  endfunction

  function automatic logic is_xlat(fault_kind_e k);
    return (k >= FK_TLB_MOD) && (k <= FK_ST_REFILL);
  endfunction

  function automatic logic keeps_addr(fault_kind_e k);
    return (k >= FK_TLB_MOD) && (k <= FK_ADR_ST);
  endfunction

  function automatic logic is_refill(fault_kind_e k);
    return (k == FK_LD_REFILL) || (k == FK_ST_REFILL);
  endfunction
endpackage

// File: rtl/exc_vector_sel.sv
`timescale 1ns/1ps
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter logic [DW-1:0] BOOT_OVF_VEC = 32'hBFC0_0200,
  parameter logic [DW-1:0] GEN_OFS      = 32'h0000_0180,
  parameter logic [DW-1:0] IRQ_OFS      = 32'h0000_0200
) (
  input  fault_kind_e     kind,
  input  logic [DW-1:0]   vbase,
  input  logic            lvl_before,
  input  logic            boot_vec,
  input  logic            irq_sep,
  output logic [DW-1:0]   handler
);
  localparam logic [DW-1:0] REFILL_OFS = '0;

  always_comb begin
    handler = vbase + GEN_OFS;
    if (is_refill(kind)) begin
      handler = lvl_before ? vbase + GEN_OFS : vbase + REFILL_OFS;
    end else if (kind == FK_IRQ) begin
      handler = irq_sep ? vbase + IRQ_OFS : vbase + GEN_OFS;
    end else if (kind == FK_OVF && boot_vec) begin
      handler = BOOT_OVF_VEC;
    end
  end
endmodule

// File: rtl/exc_state_calc.sv
`timescale 1ns/1ps
module exc_state_calc
  import exc_pkg::*;
#(
  parameter int unsigned INSN_BYTES = 4
) (
  input  fault_kind_e            kind,
  input  logic [DW-1:0]          cur_pc,
  input  logic [DW-1:0]          cur_npc,
  input  logic [DW-1:0]          fault_va,
  input  logic [CA_COP_W-1:0]    cop_id,
  input  csr_vec_t               cur,
  output csr_vec_t               nxt
);
  localparam logic [DW-1:0] STEP = DW'(INSN_BYTES);

  logic           in_slot;
  logic           switch_set;
  logic [PG_W-1:0] page;

  assign in_slot    = (cur_pc + STEP) != cur_npc;
  assign switch_set = !cur[I_STAT][ST_LVL] && !cur[I_STAT][ST_BOOT];
  assign page       = fault_va[DW-1:PG_LO];

  always_comb begin
    nxt = cur;
    // shadow-set rotation, decided on pre-entry state
    if (switch_set) begin
      nxt[I_SHADOW][SH_PREV_LO +: SH_W] = cur[I_SHADOW][SH_CUR_LO +: SH_W];
      nxt[I_SHADOW][SH_CUR_LO  +: SH_W] = cur[I_SHADOW][SH_ENTRY_LO +: SH_W];
    end
    nxt[I_STAT][ST_LVL] = 1'b1;
    // return address and cause
    nxt[I_RETPC] = in_slot ? cur_pc - STEP : cur_pc;
    nxt[I_CAUSE][CA_SLOT] = in_slot;
    nxt[I_CAUSE][CA_CODE_LO +: CA_CODE_W] = code_of(kind);
    nxt[I_CAUSE][CA_COP_LO +: CA_COP_W] = (kind == FK_COP) ? cop_id : '0;
    // address capture
    if (keeps_addr(kind)) begin
      nxt[I_FADDR] = fault_va;
    end
    if (is_xlat(kind)) begin
      nxt[I_TAG][DW-1:PG_LO]         = page;
      nxt[I_CTX][CTX_LO +: PG_W]     = page;
    end
  end
endmodule

// File: rtl/exc_csr_file.sv
`timescale 1ns/1ps
module exc_csr_file
  import exc_pkg::*;
#(
  parameter logic [DW-1:0] RST_STAT  = 32'h0040_0000,
  parameter logic [DW-1:0] RST_VBASE = 32'h8000_0000,
  localparam int unsigned  SEL_W     = $clog2(NCSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_reset,
  input  logic              take_fault,
  input  csr_vec_t          entry_val,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output csr_vec_t          regs,
  output logic [DW-1:0]     rd_data
);
  csr_vec_t regs_d;
  csr_vec_t regs_init;

  for (genvar g = 0; g < NCSR; g++) begin : g_slot
    logic [DW-1:0] on_reset;
    if (g == I_STAT) begin : g_state
      assign on_reset     = regs[g] | (DW'(1) << ST_FPU);
      assign regs_init[g] = RST_STAT;
    end else if (g == I_VBASE) begin : g_base
      assign on_reset     = regs[g];
      assign regs_init[g] = RST_VBASE;
    end else begin : g_plain
      assign on_reset     = regs[g];
      assign regs_init[g] = '0;
    end
    assign regs_d[g] = take_reset ? on_reset :
                       take_fault ? entry_val[g] :
                       (wr_en && wr_sel == SEL_W'(g)) ? wr_data : regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= regs_init;
    else        regs <= regs_d;
  end

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [31:0] BOOT_OVF_VEC = 32'hBFC0_0200,
  parameter logic [31:0] GEN_OFS      = 32'h0000_0180,
  parameter logic [31:0] IRQ_OFS      = 32'h0000_0200,
  parameter logic [31:0] RST_VBASE    = 32'h8000_0000,
  parameter int unsigned INSN_BYTES   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fault_valid,
  input  logic [3:0]  fault_kind,
  input  logic [31:0] fault_va,
  input  logic [1:0]  cop_id,
  input  logic [31:0] cur_pc,
  input  logic [31:0] cur_npc,
  input  logic        reset_req,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        entry_done,
  output logic [31:0] redir_pc,
  output logic [31:0] redir_npc,
  output logic [31:0] redir_nnpc,
  output logic [3:0]  shadow_set
);
  localparam logic [DW-1:0] STEP = DW'(INSN_BYTES);

  fault_kind_e kind;
  logic        take_reset;
  logic        take_fault;
  csr_vec_t    regs;
  csr_vec_t    entry_val;
  logic [DW-1:0] handler;
  logic [DW-1:0] target;

  // views used by the bound checker
  logic [DW-1:0] stat_q, cause_q, shadow_q, vbase_q, retpc_q;

  assign kind       = fault_kind_e'(fault_kind);
  assign take_reset = reset_req;
  assign take_fault = fault_valid && !reset_req;

  exc_state_calc #(.INSN_BYTES(INSN_BYTES)) calc_i (
    .kind     (kind),
    .cur_pc   (cur_pc),
    .cur_npc  (cur_npc),
    .fault_va (fault_va),
    .cop_id   (cop_id),
    .cur      (regs),
    .nxt      (entry_val)
  );

  exc_vector_sel #(
    .BOOT_OVF_VEC (BOOT_OVF_VEC),
    .GEN_OFS      (GEN_OFS),
    .IRQ_OFS      (IRQ_OFS)
  ) vsel_i (
    .kind       (kind),
    .vbase      (regs[I_VBASE]),
    .lvl_before (regs[I_STAT][ST_LVL]),
    .boot_vec   (regs[I_STAT][ST_BOOT]),
    .irq_sep    (regs[I_CAUSE][CA_IVSEP]),
    .handler    (handler)
  );

  exc_csr_file #(.RST_VBASE(RST_VBASE)) csr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_reset (take_reset),
    .take_fault (take_fault),
    .entry_val  (entry_val),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .regs       (regs),
    .rd_data    (rd_data)
  );

  assign target = take_reset ? RESET_VEC : handler;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_done <= 1'b0;
      redir_pc   <= '0;
      redir_npc  <= '0;
      redir_nnpc <= '0;
    end else begin
      entry_done <= take_reset || take_fault;
      if (take_reset || take_fault) begin
        redir_pc   <= target;
        redir_npc  <= target + STEP;
        redir_nnpc <= target + 2 * STEP;
      end
    end
  end

  assign shadow_set = regs[I_SHADOW][SH_CUR_LO +: SH_W];
  assign stat_q     = regs[I_STAT];
  assign cause_q    = regs[I_CAUSE];
  assign shadow_q   = regs[I_SHADOW];
  assign vbase_q    = regs[I_VBASE];
  assign retpc_q    = regs[I_RETPC];
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
  parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fault_valid,
  input logic        reset_req,
  input logic [3:0]  fault_kind,
  input logic [31:0] cur_pc,
  input logic [31:0] cur_npc,
  input logic [1:0]  cop_id,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        entry_done,
  input logic [31:0] redir_pc,
  input logic [3:0]  shadow_set,
  input logic [31:0] stat_q,
  input logic [31:0] cause_q,
  input logic [31:0] shadow_q,
  input logic [31:0] vbase_q,
  input logic [31:0] retpc_q
);
  // R2
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !reset_req |=> entry_done && stat_q[1]);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid && !reset_req |=> !entry_done);
  // R4
  straight_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !reset_req && (cur_pc + 32'd4 == cur_npc)
      |=> retpc_q == $past(cur_pc) && !cause_q[31]);
  // R5
  cop_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !reset_req && fault_kind == 4'd11
      |=> cause_q[29:28] == $past(cop_id));
  // R6
  set_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !reset_req && !stat_q[1] && !stat_q[22]
      |=> shadow_set == $past(shadow_q[15:12]));
  // R6
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid && !reset_req && stat_q[1] |=> $stable(shadow_q));
  // R12
  boot_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> entry_done && redir_pc == RESET_VEC && stat_q[29]);
  // R13
  write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (fault_valid || reset_req) && wr_sel == 3'd3 |=> $stable(vbase_q));
  // R13
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !fault_valid && !reset_req && wr_sel == 3'd3 |=> vbase_q == $past(wr_data));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.RESET_VEC(RESET_VEC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fault_valid (fault_valid),
  .reset_req   (reset_req),
  .fault_kind  (fault_kind),
  .cur_pc      (cur_pc),
  .cur_npc     (cur_npc),
  .cop_id      (cop_id),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .entry_done  (entry_done),
  .redir_pc    (redir_pc),
  .shadow_set  (shadow_set),
  .stat_q      (stat_q),
  .cause_q     (cause_q),
  .shadow_q    (shadow_q),
  .vbase_q     (vbase_q),
  .retpc_q     (retpc_q)
);

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_valid = 1'b0;
  logic [3:0]  fault_kind = '0;
  logic [31:0] fault_va = '0;
  logic [1:0]  cop_id = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_npc = '0;
  logic        reset_req = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        entry_done;
  logic [31:0] redir_pc, redir_npc, redir_nnpc;
  logic [3:0]  shadow_set;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m [8];
  logic        exp_done;
  logic [31:0] exp_tgt;

  always #5 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fault_valid(fault_valid), .fault_kind(fault_kind),
    .fault_va(fault_va), .cop_id(cop_id), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .reset_req(reset_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .entry_done(entry_done),
    .redir_pc(redir_pc), .redir_npc(redir_npc), .redir_nnpc(redir_nnpc),
    .shadow_set(shadow_set)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] want_code(int k);
    case (k)
      0: return 5'h0;  1: return 5'h1;  2, 3: return 5'h2;  4, 5: return 5'h3;
      6: return 5'h4;  7: return 5'h5;  8: return 5'h8;     9: return 5'h9;
      10: return 5'hA; 11: return 5'hB; 12: return 5'hC;
      default: return 5'hD;
    endcase
  endfunction

  task automatic model_edge(bit fv, bit rr, int k, logic [31:0] pc, logic [31:0] npc,
                            logic [31:0] va, logic [1:0] cid, bit we, int ws, logic [31:0] wd);
    logic lvl, bev, iv, slot;
    logic [31:0] base;
    logic [3:0] ess;
    exp_done = 1'b0;
    if (rr) begin
      exp_done = 1'b1;
      exp_tgt = 32'hBFC0_0000;
      m[0][29] = 1'b1;
    end else if (fv) begin
      lvl = m[0][1]; bev = m[0][22]; iv = m[1][23]; base = m[3];
      if (k == 3 || k == 5)      exp_tgt = lvl ? base + 32'h180 : base;
      else if (k == 0)           exp_tgt = iv ? base + 32'h200 : base + 32'h180;
      else if (k == 12 && bev)   exp_tgt = 32'hBFC0_0200;
      else                       exp_tgt = base + 32'h180;
      if (!lvl && !bev) begin
        ess = m[2][15:12];
        m[2][9:6] = m[2][3:0];
        m[2][3:0] = ess;
      end
      m[0][1] = 1'b1;
      slot = (pc + 32'd4) != npc;
      m[4] = slot ? pc - 32'd4 : pc;
      m[1][31] = slot;
      m[1][6:2] = want_code(k);
      m[1][29:28] = (k == 11) ? cid : 2'b00;
      if (k >= 1 && k <= 7) m[5] = va;
      if (k >= 1 && k <= 5) begin
        m[6][31:13] = va[31:13];
        m[7][22:4]  = va[31:13];
      end
      exp_done = 1'b1;
    end else if (we) begin
      m[ws] = wd;
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #0.5;
      chk(req, $sformatf("reg%0d", i), rd_data, m[i]);
    end
  endtask

  task automatic cyc(string req, bit fv, bit rr, int k, logic [31:0] pc, logic [31:0] npc,
                     logic [31:0] va, logic [1:0] cid, bit we, int ws, logic [31:0] wd);
    fault_valid = fv; reset_req = rr; fault_kind = 4'(k); cur_pc = pc; cur_npc = npc;
    fault_va = va; cop_id = cid; wr_en = we; wr_sel = 3'(ws); wr_data = wd;
    @(posedge clk);
    model_edge(fv, rr, k, pc, npc, va, cid, we, ws, wd);
    @(negedge clk);
    fault_valid = 1'b0; reset_req = 1'b0; wr_en = 1'b0;
    chk(req, "entry_done", 32'(entry_done), 32'(exp_done));
    if (exp_done) begin
      chk(req, "redir_pc", redir_pc, exp_tgt);
      chk(req, "redir_npc", redir_npc, exp_tgt + 32'd4);
      chk(req, "redir_nnpc", redir_nnpc, exp_tgt + 32'd8);
    end
    chk(req, "shadow_set", 32'(shadow_set), 32'(m[2][3:0]));
    sweep(req);
  endtask

  task automatic wr(string req, int ws, logic [31:0] wd);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, 1, ws, wd);
  endtask

  task automatic flt(string req, int k, logic [31:0] pc, logic [31:0] npc,
                     logic [31:0] va, logic [1:0] cid);
    cyc(req, 1, 0, k, pc, npc, va, cid, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    m[0] = 32'h0040_0000;
    m[3] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    chk("R1", "entry_done", 32'(entry_done), 0);
    sweep("R1");
    // R13: plain writes
    wr("R13", 0, 32'h0000_0000);
    wr("R13", 2, 32'h0000_5002);
    wr("R13", 3, 32'h8000_1000);
    // R3 R7 R4 R6: straight-line system call, shadow rotates
    flt("R6", 8, 32'h0000_0400, 32'h0000_0404, 32'h0, 2'd0);
    // R4: delay slot entry with level already set, no rotation (R6)
    flt("R4", 9, 32'h0000_0500, 32'h0000_0900, 32'h0, 2'd0);
    // R8: load refill at level 1 goes to +0x180
    flt("R8", 3, 32'h0000_0600, 32'h0000_0604, 32'h1234_5678, 2'd0);
    wr("R8", 0, 32'h0000_0000);
    wr("R6", 2, 32'h0000_A003);
    // R8 R11: store refill at level 0 goes to +0x000, tag/context updated
    flt("R11", 5, 32'h0000_0700, 32'h0000_0704, 32'hABCD_E123, 2'd0);
    // R5: coprocessor number, then cleared by a trap
    flt("R5", 11, 32'h0000_0800, 32'h0000_0804, 32'h0, 2'd3);
    flt("R5", 13, 32'h0000_0808, 32'h0000_080C, 32'h0, 2'd3);
    // R9: interrupt vector with and without the separate-vector bit
    wr("R9", 1, 32'h0080_0000);
    wr("R9", 0, 32'h0000_0000);
    flt("R9", 0, 32'h0000_0900, 32'h0000_0A00, 32'h0, 2'd0);
    wr("R9", 1, 32'h0000_0000);
    flt("R9", 0, 32'h0000_0910, 32'h0000_0914, 32'h0, 2'd0);
    // R10: overflow with boot-vector bit set, then clear (R7); no rotation with boot set (R6)
    wr("R10", 0, 32'h0040_0000);
    flt("R10", 12, 32'h0000_0A00, 32'h0000_0A04, 32'h0, 2'd0);
    wr("R7", 0, 32'h0000_0000);
    flt("R7", 12, 32'h0000_0A10, 32'h0000_0A14, 32'h0, 2'd0);
    // R11: address errors capture the address only
    flt("R11", 6, 32'h0000_0B00, 32'h0000_0B04, 32'h5555_0001, 2'd0);
    flt("R11", 7, 32'h0000_0B10, 32'h0000_0B14, 32'h6666_0002, 2'd0);
    // R3: every kind code, alternating slot/straight, level cleared each time
    for (int k = 0; k < 16; k++) begin
      wr("R3", 0, 32'h0000_0000);
      flt("R3", k, 32'h0000_1000 + 32'(k * 16),
          (k % 2 == 1) ? 32'h0000_3000 : 32'h0000_1004 + 32'(k * 16),
          32'h0F0F_0000 + 32'(k), 2'(k));
    end
    // R12: reset entry beats a simultaneous fault and write
    cyc("R12", 1, 1, 8, 32'h0000_2000, 32'h0000_2004, 32'h0, 2'd0, 1, 3, 32'hDEAD_0000);
    // R13: write dropped when an entry happens
    cyc("R13", 1, 0, 8, 32'h0000_2100, 32'h0000_2104, 32'h0, 2'd0, 1, 3, 32'hDEAD_0000);
    // R2: idle cycle keeps entry_done low
    cyc("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R2) act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule